// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM with 1M words of 16 bits. A request carries a 20-bit word address, a direction, a 16-bit write word and a 2-bit lane mask. The controller turns it into the RAM strobe sequence and answers with a one-cycle acknowledge. On a read, the returned word comes back in the acknowledge cycle. The RAM is selected only when its active-low enable is low and its active-high enable is high together. Each 8-bit lane has its own active-low enable, and the data lines are shared in both directions.

The access time is a parameter in picoseconds. The clock period is also a parameter. The controller rounds their ratio up to a whole number of wait states, with a minimum of one. The strobes are held for that many cycles before the RAM is sampled or the write strobe is released.

The controller releases the data bus except during the write phase. The write strobe is raised one cycle before the address and lane enables are allowed to move. A request with an empty lane mask is answered without touching the RAM.

Top module: `sram_async_ctrl`

## Requirements
- R1: In reset and between transactions the RAM is deselected: `ram_ce1_n`=1, `ram_ce2`=0, `ram_we_n`=1, `ram_oe_n`=1, both lane enables 1, `ram_dq_oe`=0 and `ack`=0.
- R2: During a write the RAM is selected, `ram_dq_oe`=1 and `ram_dq_out` carries the request's write word. Lane enable `ram_ble_n` (bits 7:0) is low exactly when mask bit 0 is set, and `ram_bhe_n` (bits 15:8) is low exactly when mask bit 1 is set.
- R3: The wait-state count WAIT is ceil(T_AA_PS / CLK_PS), with a minimum of 1. With 10000 ps and 4000 ps, WAIT is 3. During a write, `ram_we_n` is low for exactly WAIT cycles.
- R4: During a read the RAM is selected with `ram_oe_n`=0 and `ram_we_n`=1 for WAIT cycles. The bus is then sampled into `rdata`, and lanes whose mask bit is clear return 0.
- R5: While `ram_we_n` is low, and in the cycle after it rises, the address and lane enables do not change.
- R6: `ram_dq_oe` is never high while `ram_oe_n` is low, and it is low in the cycle before `ram_oe_n` falls.
- R7: `ack` is high for exactly one cycle per request, and `rdata` is valid in that cycle. Counting the accepting clock edge as edge 1, `ack` rises at edge WAIT+1 for a read and at edge WAIT+3 for a write.
- R8: A request with mask 00 is acknowledged at edge 1. It touches no strobe, the data bus or memory, and on a read it returns 0.
- R9: A request is accepted only in the idle state. Its address, data and mask are captured at acceptance, so later changes on the request inputs have no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask, bit 0 = low byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, valid with ack |
| ram_addr | output | 20 | RAM address |
| ram_ce1_n | output | 1 | Active-low chip enable |
| ram_ce2 | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_ble_n | output | 1 | Active-low low-lane enable |
| ram_bhe_n | output | 1 | Active-low high-lane enable |
| ram_dq_out | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 16 | Data arriving from the RAM |

## Verification
The bench drives each request just after a falling edge. It then counts rising edges until `ack` is seen at a falling edge, and compares that count with WAIT+1 for a read, WAIT+3 for a write and 1 for an empty mask. Read data is compared in the same sampling slot as `ack`, and the bench checks `ack` low again one edge later. Strobe monitors sample at falling edges, half a cycle after each registered change. They count the write-strobe cycles and flag any address move, wrong write word or bus overlap during the transaction.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W_SETUP,
      ST_W_PULSE,
      ST_W_HOLD,
      ST_R_ACCESS,
      ST_ACK
   } ctrl_state_e;

   // Round the access time up to whole clock periods, never below one.
   function automatic int unsigned wait_states(input int unsigned taa_ps,
                                               input int unsigned clk_ps);
      int unsigned n;
      n = (taa_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int unsigned WAIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int unsigned CW = (WAIT > 1) ? $clog2(WAIT) : 1;
   localparam logic [CW-1:0] START = CW'(WAIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= START;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= START); // R3
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANES-1:0]        mask,
   input  logic                    active,
   input  logic [LANES-1:0]        rd_mask,
   input  logic [LANES*LANE_W-1:0] bus_in,
   output logic [LANES-1:0]        lane_en_n,
   output logic [LANES*LANE_W-1:0] bus_masked
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_en_n[g] = !(active && mask[g]);
      assign bus_masked[g*LANE_W +: LANE_W] =
         rd_mask[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned T_AA_PS = 10000,
   parameter int unsigned CLK_PS  = 4000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic                        req_we,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [DATA_W/LANE_W-1:0]    req_mask,
   output logic                        ack,
   output logic [DATA_W-1:0]           rdata,
   output logic [ADDR_W-1:0]           ram_addr,
   output logic                        ram_ce1_n,
   output logic                        ram_ce2,
   output logic                        ram_we_n,
   output logic                        ram_oe_n,
   output logic                        ram_ble_n,
   output logic                        ram_bhe_n,
   output logic [DATA_W-1:0]           ram_dq_out,
   output logic                        ram_dq_oe,
   input  logic [DATA_W-1:0]           ram_dq_in
);
   localparam int unsigned LANES = DATA_W / LANE_W;
   localparam int unsigned WAIT  = wait_states(T_AA_PS, CLK_PS);

   if (LANES != 2 || LANES * LANE_W != DATA_W) begin : g_bad_width
      $error("sram_async_ctrl: the bus must be two lanes wide");
   end
   if (ADDR_W < 1 || CLK_PS < 1) begin : g_bad_param
      $error("sram_async_ctrl: address width and clock period must be positive");
   end

   ctrl_state_e          state_q, state_d;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [LANES-1:0]     mask_q, mask_d, lane_en_n_d;
   logic [DATA_W-1:0]    rd_masked;
   logic                 accept, expired, timer_load, active_d, writing_d;

   assign accept = (state_q == ST_IDLE) && req;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:
            if (req) begin
               if (req_mask == '0) state_d = ST_ACK;
               else if (req_we)    state_d = ST_W_SETUP;
               else                state_d = ST_R_ACCESS;
            end
         ST_W_SETUP:  state_d = ST_W_PULSE;
         ST_W_PULSE:  if (expired) state_d = ST_W_HOLD;
         ST_W_HOLD:   state_d = ST_ACK;
         ST_R_ACCESS: if (expired) state_d = ST_ACK;
         ST_ACK:      state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign timer_load = (state_d != state_q) &&
                       (state_d == ST_W_PULSE || state_d == ST_R_ACCESS);
   assign writing_d  = (state_d == ST_W_SETUP) || (state_d == ST_W_PULSE) ||
                       (state_d == ST_W_HOLD);
   assign active_d   = writing_d || (state_d == ST_R_ACCESS);
   assign mask_d     = accept ? req_mask : mask_q;

   sram_wait_timer #(.WAIT(WAIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .expired (expired)
   );

   sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .mask       (mask_d),
      .active     (active_d),
      .rd_mask    (mask_q),
      .bus_in     (ram_dq_in),
      .lane_en_n  (lane_en_n_d),
      .bus_masked (rd_masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         wdata_q   <= '0;
         mask_q    <= '0;
         rdata     <= '0;
         ack       <= 1'b0;
         ram_ce1_n <= 1'b1;
         ram_ce2   <= 1'b0;
         ram_we_n  <= 1'b1;
         ram_oe_n  <= 1'b1;
         ram_ble_n <= 1'b1;
         ram_bhe_n <= 1'b1;
         ram_dq_oe <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
         end
         if (state_q == ST_R_ACCESS && expired)
            rdata <= rd_masked;
         else if (accept && req_mask == '0)
            rdata <= '0;
         ack       <= (state_d == ST_ACK);
         ram_ce1_n <= !active_d;
         ram_ce2   <= active_d;
         ram_we_n  <= (state_d != ST_W_PULSE);
         ram_oe_n  <= (state_d != ST_R_ACCESS);
         ram_ble_n <= lane_en_n_d[0];
         ram_bhe_n <= lane_en_n_d[1];
         ram_dq_oe <= writing_d;
      end
   end

   assign ram_addr   = addr_q;
   assign ram_dq_out = wdata_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n &&
                                ram_ble_n && ram_bhe_n && !ram_dq_oe)); // R1
   AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_ce1_n && ram_ce2 && ram_dq_oe)); // R2
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_oe_n |-> ram_we_n); // R4
   AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |=> ($stable(ram_addr) && $stable(ram_ble_n) && $stable(ram_bhe_n))); // R5
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_oe_n |-> !ram_dq_oe); // R6
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_oe_n) |-> !$past(ram_dq_oe)); // R6
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R7
   AST_NULL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && req && req_mask == '0) |=>
         (ack && ram_ce1_n && ram_we_n && ram_oe_n && !ram_dq_oe)); // R8
   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(ram_addr)); // R9
endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
   localparam int W = 3; // R3: ceil(10000 ps / 4000 ps)

   typedef struct packed {
      logic        we;
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [1:0]  mask;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 20'h00012, 16'hA5C3, 2'b11, 16'h0000},
      '{1'b0, 20'h00012, 16'h0000, 2'b11, 16'hA5C3},
      '{1'b1, 20'hFFF34, 16'h1234, 2'b01, 16'h0000},
      '{1'b0, 20'hFFF34, 16'h0000, 2'b11, 16'h0034},
      '{1'b1, 20'hFFF34, 16'h9900, 2'b10, 16'h0000},
      '{1'b0, 20'hFFF34, 16'h0000, 2'b11, 16'h9934},
      '{1'b0, 20'hFFF34, 16'h0000, 2'b01, 16'h0034},
      '{1'b0, 20'hFFF34, 16'h0000, 2'b10, 16'h9900},
      '{1'b1, 20'h00012, 16'hFFFF, 2'b00, 16'h0000},
      '{1'b0, 20'h00012, 16'h0000, 2'b11, 16'hA5C3},
      '{1'b0, 20'h00012, 16'h0000, 2'b00, 16'h0000}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, req_we = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic ack;
   logic [15:0] rdata, ram_dq_out, ram_dq_in;
   logic [19:0] ram_addr;
   logic ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_ble_n, ram_bhe_n, ram_dq_oe;

   int n_chk = 0, n_fail = 0;
   int we_low = 0, addr_err = 0, data_err = 0, overlap = 0;
   logic strobe_seen = 1'b0, in_txn = 1'b0;
   logic [19:0] cur_addr = '0;
   logic [15:0] cur_wdata = '0;
   logic [15:0] mem [256];

   always #2 clk = ~clk;

   sram_async_ctrl #(.T_AA_PS(10000), .CLK_PS(4000)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_mask(req_mask), .ack(ack), .rdata(rdata),
      .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
      .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_ble_n(ram_ble_n),
      .ram_bhe_n(ram_bhe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
      .ram_dq_in(ram_dq_in)
   );

   // RAM model: disabled lanes and an undriven bus show filler patterns.
   wire sel = !ram_ce1_n && ram_ce2;
   assign ram_dq_in = (sel && !ram_oe_n && ram_we_n) ?
      {ram_bhe_n ? 8'hEE : mem[ram_addr[7:0]][15:8],
       ram_ble_n ? 8'hEE : mem[ram_addr[7:0]][7:0]} : 16'h5A5A;

   always @(negedge clk) begin
      if (sel && !ram_we_n) begin
         if (!ram_ble_n) mem[ram_addr[7:0]][7:0]  <= ram_dq_out[7:0];
         if (!ram_bhe_n) mem[ram_addr[7:0]][15:8] <= ram_dq_out[15:8];
      end
      if (ram_dq_oe && !ram_oe_n) overlap++;
      if (in_txn) begin
         if (!ram_we_n) we_low++;
         if (sel || !ram_we_n || !ram_oe_n || !ram_ble_n || !ram_bhe_n || ram_dq_oe)
            strobe_seen = 1'b1;
         if (sel && ram_addr != cur_addr) addr_err++;
         if (ram_dq_oe && ram_dq_out != cur_wdata) data_err++;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic chk_idle(input string rq);
      chk(rq, {ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_ble_n, ram_bhe_n,
               ram_dq_oe, ack}, 8'b1011_1100);
   endtask

   task automatic run(input vec_t v);
      int lat = 0;
      int exp_lat;
      @(negedge clk);
      cur_addr = v.addr; cur_wdata = v.wdata; we_low = 0; strobe_seen = 1'b0;
      in_txn = 1'b1;
      req = 1'b1; req_we = v.we; req_addr = v.addr; req_wdata = v.wdata; req_mask = v.mask;
      do begin
         @(posedge clk); lat++;
         @(negedge clk);
         if (lat == 1) begin   // R9: inputs move after acceptance
            req_addr = ~v.addr; req_wdata = ~v.wdata;
         end
      end while (!ack && lat < 40);
      exp_lat = (v.mask == 2'b00) ? 1 : (v.we ? W + 3 : W + 1);
      chk("R7 ack latency", lat, exp_lat);
      if (!v.we) chk("R4 read data", rdata, v.exp);
      chk("R3 write strobe cycles", we_low, (v.we && v.mask != 0) ? W : 0);
      chk("R8 strobe activity", strobe_seen, v.mask != 0);
      req = 1'b0; in_txn = 1'b0;
      @(negedge clk);
      chk("R7 ack single cycle", ack, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 after reset");

      for (int i = 0; i < NV; i++) run(VECS[i]);

      chk_idle("R1 between transactions");
      chk("R8 empty write left memory", mem[8'h12], 16'hA5C3);
      chk("R5 R9 address held", addr_err, 0);
      chk("R2 write word on bus", data_err, 0);
      chk("R6 bus overlap", overlap, 0);
      chk("R2 low lane only", mem[8'h34], 16'h9934);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule